// File: doc/BRIEF.md
# Handshake Command/Response Serial Engine

This block is the device end of a byte-at-a-time command and reply exchange with a host processor. The host puts one byte at a time into a shift register and signals each transfer on a parallel port with two active-low lines: a request line the host pulls low, and an acknowledge line that the device answers on. The engine looks at the port only when the host writes a new value. It sorts each change into idle, acknowledge-release, request or illegal. On each request it moves a three-phase sequence forward: take the command byte, collect the arguments, then hand back the reply.

Argument and reply lengths are computed from the command code. A length can also be in-band, in which case the first byte after the command (for arguments) or the first reply byte (for the reply) carries the count. When all arguments are in, the engine pulses a start strobe to an external dispatcher. The dispatcher reads the buffered arguments, writes the reply bytes into the engine's reply buffer and strobes done with the reply size. Until done arrives, the engine ignores host port writes.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the port value is 0x18 (acknowledge bit 3 and request bit 4 both high). The engine is in the idle phase, `busy` is low, and every strobe output is low.
- R2: A port write is evaluated only if its value differs from the current port value. A write of the same value changes no output.
- R3: A changed write with bit 4 high and bit 3 low is a release: the port takes the written value with bit 3 forced high. A changed write with both bits high is only stored. A changed write with both bits low is stored and pulses `hs_invalid` for one cycle, with no other effect.
- R4: A changed write with bit 4 low and bit 3 high is a request. The port takes the written value with bit 3 forced low, and the byte is handled according to the current phase.
- R5: In the idle phase a request with `sr_dir` = 1 (host to device) captures `sr_host_byte` as the command. The argument count is cmd[2:0] and the reply count is cmd[5:3]; a field value of 7 means the count is in-band.
- R6: In the command phase, with an in-band argument count, the first byte received sets the count. Each later byte is stored in the next argument slot while fewer than 32 are stored, and the stored bytes can be read through `disp_arg_idx`/`disp_arg_byte`.
- R7: When the stored argument count equals the argument length, `disp_start` pulses for one cycle with `disp_cmd` and `disp_arg_cnt`. `busy` then stays high until `disp_done`, and port writes are ignored while `busy` is high.
- R8: Each accepted byte pulses `sr_irq` for one cycle. A request in the wrong direction for the phase (`sr_dir` = 0 in idle or command phase, 1 in reply phase) pulses `dir_error` instead, with no `sr_irq` and no phase change. The acknowledge bit still goes low.
- R9: In the reply phase, with an in-band reply count, the reply size is sent first on `sr_dev_byte`. Reply bytes then follow in order, one per request. The engine returns to idle when the sent count equals the reply count; a reply count of 0 returns it to idle at `disp_done`.
- R10: When `disp_known` = 0 at done, a fixed reply count sends that many 0x00 bytes regardless of the reply buffer contents, and an in-band reply count sends a size of 0.
- R11: When `disp_known` = 1, the reply size is `disp_rsp_size` and the reply bytes are the values written through `disp_rsp_we`/`disp_rsp_idx`/`disp_rsp_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr_en | input | 1 | Host writes the handshake port this cycle |
| port_wr_data | input | 8 | Value written to the port |
| port_q | output | 8 | Current port value, including the acknowledge bit |
| sr_dir | input | 1 | Shift direction: 1 host to device, 0 device to host |
| sr_host_byte | input | 8 | Byte shifted in by the host |
| sr_dev_byte | output | 8 | Byte offered to the host |
| sr_irq | output | 1 | One-cycle pulse per accepted byte |
| hs_invalid | output | 1 | One-cycle pulse on a both-low handshake |
| dir_error | output | 1 | One-cycle pulse on a wrong-direction request |
| busy | output | 1 | Waiting for the dispatcher |
| disp_start | output | 1 | One-cycle dispatch pulse |
| disp_cmd | output | 8 | Latched command byte |
| disp_arg_cnt | output | 6 | Number of stored arguments |
| disp_arg_idx | input | 5 | Argument read index |
| disp_arg_byte | output | 8 | Argument at the read index |
| disp_rsp_we | input | 1 | Reply buffer write enable |
| disp_rsp_idx | input | 5 | Reply buffer write index |
| disp_rsp_byte | input | 8 | Reply buffer write data |
| disp_done | input | 1 | Dispatcher finished |
| disp_known | input | 1 | Command was recognised |
| disp_rsp_size | input | 6 | Reply size when recognised |

## Verification
Every result is registered. A port write presented before clock edge N shows up in `port_q`, `sr_irq`, `sr_dev_byte`, `dir_error`, `hs_invalid`, `disp_start` and `busy` just after edge N. `disp_done` moves the phase at its own edge, and `disp_arg_byte` is a combinational read. The bench drives inputs on falling edges and updates its reference model on rising edges. It compares the model with all registered outputs on the next falling edge, which is one full register stage after the stimulus. The scenario tasks check received bytes and dispatch arguments at the same falling edge, when each host write completes.

// File: rtl/hsce_pkg.sv
package hsce_pkg;

  localparam int ACK_BIT = 3;
  localparam int REQ_BIT = 4;
  localparam logic [7:0] PORT_IDLE = 8'h18;
  localparam logic [2:0] INBAND_CODE = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WAIT, ST_RSP} eng_state_e;
  typedef enum logic [1:0] {HS_QUIET, HS_RELEASE, HS_REQUEST, HS_BAD} hs_kind_e;

  // Length code: 0..6 literal, 7 means the count travels in-band (-1).
  function automatic logic signed [8:0] code_to_len(input logic [2:0] code);
    if (code == INBAND_CODE) return -9'sd1;
    return $signed({6'd0, code});
  endfunction

  function automatic logic signed [8:0] arg_len_of(input logic [7:0] cmd);
    return code_to_len(cmd[2:0]);
  endfunction

  function automatic logic signed [8:0] rsp_len_of(input logic [7:0] cmd);
    return code_to_len(cmd[5:3]);
  endfunction

  // True when a non-negative length equals the running count.
  function automatic logic count_reached(input logic [7:0] cnt,
                                         input logic signed [8:0] lim);
    return !lim[8] && ({1'b0, cnt} == lim[8:0]);
  endfunction

endpackage

// File: rtl/hsce_hs_decode.sv
module hsce_hs_decode
  import hsce_pkg::*;
(
  input  logic       wr_en,
  input  logic       blocked,
  input  logic [7:0] wr_data,
  input  logic [7:0] cur,
  output logic       changed,
  output hs_kind_e   kind
);

  assign changed = wr_en && !blocked && (wr_data != cur);

  always_comb begin
    unique case ({wr_data[REQ_BIT], wr_data[ACK_BIT]})
      2'b11:   kind = HS_QUIET;
      2'b10:   kind = HS_RELEASE;
      2'b01:   kind = HS_REQUEST;
      default: kind = HS_BAD;
    endcase
  end

endmodule

// File: rtl/hsce_byte_store.sv
module hsce_byte_store #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++)
        if (widx == IW'(i)) cells[i] <= wdata;
    end
  end

  assign rdata = cells[ridx];

endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
  import hsce_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr_en,
  input  logic [7:0]    port_wr_data,
  output logic [7:0]    port_q,
  input  logic          sr_dir,
  input  logic [7:0]    sr_host_byte,
  output logic [7:0]    sr_dev_byte,
  output logic          sr_irq,
  output logic          hs_invalid,
  output logic          dir_error,
  output logic          busy,
  output logic          disp_start,
  output logic [7:0]    disp_cmd,
  output logic [CW-1:0] disp_arg_cnt,
  input  logic [IW-1:0] disp_arg_idx,
  output logic [7:0]    disp_arg_byte,
  input  logic          disp_rsp_we,
  input  logic [IW-1:0] disp_rsp_idx,
  input  logic [7:0]    disp_rsp_byte,
  input  logic          disp_done,
  input  logic          disp_known,
  input  logic [CW-1:0] disp_rsp_size
);

  localparam logic [CW-1:0] CAP = CW'(BUF_DEPTH);

  eng_state_e        state_q, state_d;
  logic [7:0]        port_d, cmd_q, cmd_d, sr_d;
  logic signed [8:0] alen_q, alen_d, rlen_q, rlen_d;
  logic [CW-1:0]     apos_q, apos_d, rpos_q, rpos_d, rsize_q, rsize_d;
  logic              zero_q, zero_d;
  logic              irq_d, bad_d, derr_d, start_d;
  logic              arg_we;
  logic [7:0]        rsp_rd;

  // Named events for the checker.
  logic     ev_chg;
  hs_kind_e ev_kind;

  hsce_hs_decode u_dec (
    .wr_en   (port_wr_en),
    .blocked (state_q == ST_WAIT),
    .wr_data (port_wr_data),
    .cur     (port_q),
    .changed (ev_chg),
    .kind    (ev_kind)
  );

  hsce_byte_store #(.DEPTH(BUF_DEPTH)) u_args (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arg_we),
    .widx  (apos_q[IW-1:0]),
    .wdata (sr_host_byte),
    .ridx  (disp_arg_idx),
    .rdata (disp_arg_byte)
  );

  hsce_byte_store #(.DEPTH(BUF_DEPTH)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (disp_rsp_we),
    .widx  (disp_rsp_idx),
    .wdata (disp_rsp_byte),
    .ridx  (rpos_q[IW-1:0]),
    .rdata (rsp_rd)
  );

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    cmd_d   = cmd_q;
    sr_d    = sr_dev_byte;
    alen_d  = alen_q;
    rlen_d  = rlen_q;
    apos_d  = apos_q;
    rpos_d  = rpos_q;
    rsize_d = rsize_q;
    zero_d  = zero_q;
    irq_d   = 1'b0;
    bad_d   = 1'b0;
    derr_d  = 1'b0;
    start_d = 1'b0;
    arg_we  = 1'b0;

    if (state_q == ST_WAIT) begin
      if (disp_done) begin
        if (disp_known)   rsize_d = disp_rsp_size;
        else if (rlen_q[8]) rsize_d = '0;
        else              rsize_d = rlen_q[CW-1:0];
        zero_d  = !disp_known;
        rpos_d  = '0;
        state_d = (rlen_q == 9'sd0) ? ST_IDLE : ST_RSP;
      end
    end else if (ev_chg) begin
      port_d = port_wr_data;
      unique case (ev_kind)
        HS_RELEASE: port_d[ACK_BIT] = 1'b1;
        HS_BAD:     bad_d = 1'b1;
        HS_REQUEST: begin
          port_d[ACK_BIT] = 1'b0;
          unique case (state_q)
            ST_IDLE: begin
              if (sr_dir) begin
                cmd_d   = sr_host_byte;
                alen_d  = arg_len_of(sr_host_byte);
                rlen_d  = rsp_len_of(sr_host_byte);
                apos_d  = '0;
                rpos_d  = '0;
                state_d = ST_CMD;
                irq_d   = 1'b1;
              end else begin
                derr_d = 1'b1;
              end
            end
            ST_CMD: begin
              if (sr_dir) begin
                if (alen_q[8]) begin
                  alen_d = $signed({1'b0, sr_host_byte});
                end else if (apos_q < CAP) begin
                  arg_we = 1'b1;
                  apos_d = apos_q + 1'b1;
                end
                irq_d = 1'b1;
              end else begin
                derr_d = 1'b1;
              end
            end
            default: begin
              if (!sr_dir) begin
                if (rlen_q[8]) begin
                  sr_d   = 8'(rsize_q);
                  rlen_d = $signed(9'(rsize_q));
                end else if (rpos_q < rsize_q) begin
                  sr_d   = zero_q ? 8'h00 : rsp_rd;
                  rpos_d = rpos_q + 1'b1;
                end
                irq_d = 1'b1;
              end else begin
                derr_d = 1'b1;
              end
            end
          endcase
          if (state_d == ST_CMD && count_reached(8'(apos_d), alen_d)) begin
            start_d = 1'b1;
            state_d = ST_WAIT;
          end
          if (state_d == ST_RSP && count_reached(8'(rpos_d), rlen_d))
            state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      port_q      <= PORT_IDLE;
      cmd_q       <= '0;
      sr_dev_byte <= '0;
      alen_q      <= '0;
      rlen_q      <= '0;
      apos_q      <= '0;
      rpos_q      <= '0;
      rsize_q     <= '0;
      zero_q      <= 1'b0;
      sr_irq      <= 1'b0;
      hs_invalid  <= 1'b0;
      dir_error   <= 1'b0;
      disp_start  <= 1'b0;
    end else begin
      state_q     <= state_d;
      port_q      <= port_d;
      cmd_q       <= cmd_d;
      sr_dev_byte <= sr_d;
      alen_q      <= alen_d;
      rlen_q      <= rlen_d;
      apos_q      <= apos_d;
      rpos_q      <= rpos_d;
      rsize_q     <= rsize_d;
      zero_q      <= zero_d;
      sr_irq      <= irq_d;
      hs_invalid  <= bad_d;
      dir_error   <= derr_d;
      disp_start  <= start_d;
    end
  end

  assign busy         = (state_q == ST_WAIT);
  assign disp_cmd     = cmd_q;
  assign disp_arg_cnt = apos_q;

endmodule

// File: rtl/hs_cmd_engine_chk.sv
module hs_cmd_engine_chk
  import hsce_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ev_chg,
  input hs_kind_e   ev_kind,
  input logic       port_wr_en,
  input logic [7:0] port_wr_data,
  input logic [7:0] port_q,
  input logic       sr_irq,
  input logic       dir_error,
  input logic       hs_invalid,
  input logic       busy,
  input logic       disp_start
);

  p_release_sets_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chg && ev_kind == HS_RELEASE) |=> port_q[ACK_BIT]);

  p_bad_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chg && ev_kind == HS_BAD) |=> (hs_invalid && !sr_irq));

  p_request_drops_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chg && ev_kind == HS_REQUEST) |=> !port_q[ACK_BIT]);

  p_same_value_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr_en && port_wr_data == port_q) |=>
      ($stable(port_q) && !sr_irq && !dir_error && !hs_invalid));

  p_dir_error_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dir_error |-> !sr_irq);

  p_start_enters_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |-> busy);

  p_busy_freezes_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(port_q));

endmodule

bind hs_cmd_engine hs_cmd_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_chg       (ev_chg),
  .ev_kind      (ev_kind),
  .port_wr_en   (port_wr_en),
  .port_wr_data (port_wr_data),
  .port_q       (port_q),
  .sr_irq       (sr_irq),
  .dir_error    (dir_error),
  .hs_invalid   (hs_invalid),
  .busy         (busy),
  .disp_start   (disp_start)
);

// File: tb/hs_cmd_engine_tb.sv
module hs_cmd_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_wr_en = 1'b0;
  logic [7:0] port_wr_data = '0;
  logic [7:0] port_q;
  logic       sr_dir = 1'b1;
  logic [7:0] sr_host_byte = '0;
  logic [7:0] sr_dev_byte;
  logic       sr_irq, hs_invalid, dir_error, busy, disp_start;
  logic [7:0] disp_cmd;
  logic [5:0] disp_arg_cnt;
  logic [4:0] disp_arg_idx = '0;
  logic [7:0] disp_arg_byte;
  logic       disp_rsp_we = 1'b0;
  logic [4:0] disp_rsp_idx = '0;
  logic [7:0] disp_rsp_byte = '0;
  logic       disp_done = 1'b0;
  logic       disp_known = 1'b0;
  logic [5:0] disp_rsp_size = '0;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  logic cmp_en = 1'b0;

  always #5 clk = ~clk;

  hs_cmd_engine u_dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_code(input int code);
    return (code == 7) ? -1 : code;
  endfunction
  function automatic logic [7:0] arg_of(input logic [7:0] c, input int i);
    return 8'(int'(c) + 3 * i + 5);
  endfunction
  function automatic logic [7:0] rep_of(input logic [7:0] c, input int i);
    return c ^ 8'(i * 7 + 1);
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  int   m_state, m_alen, m_rlen, m_apos, m_rpos, m_size;
  int   m_mem [32];
  logic m_zero, m_irq, m_start, m_bad, m_derr;
  logic [7:0] m_port, m_sr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_port = 8'h18; m_sr = 8'h00; m_irq = 0; m_start = 0;
      m_bad = 0; m_derr = 0; m_zero = 0; m_alen = 0; m_rlen = 0;
      m_apos = 0; m_rpos = 0; m_size = 0;
      for (int i = 0; i < 32; i++) m_mem[i] = 0;
    end else begin
      m_irq = 0; m_start = 0; m_bad = 0; m_derr = 0;
      if (disp_rsp_we) m_mem[disp_rsp_idx] = int'(disp_rsp_byte);
      if (m_state == 2) begin
        if (disp_done) begin
          m_size = disp_known ? int'(disp_rsp_size) : ((m_rlen < 0) ? 0 : m_rlen);
          m_zero = !disp_known;
          m_rpos = 0;
          m_state = (m_rlen == 0) ? 0 : 3;
        end
      end else if (port_wr_en && port_wr_data != m_port) begin
        m_port = port_wr_data;
        if (port_wr_data[4] && !port_wr_data[3]) m_port[3] = 1'b1;
        else if (!port_wr_data[4] && !port_wr_data[3]) m_bad = 1;
        else if (!port_wr_data[4] && port_wr_data[3]) begin
          m_port[3] = 1'b0;
          if (m_state == 0) begin
            if (sr_dir) begin
              m_alen = len_code(int'(sr_host_byte) % 8);
              m_rlen = len_code((int'(sr_host_byte) / 8) % 8);
              m_apos = 0; m_rpos = 0; m_state = 1; m_irq = 1;
            end else m_derr = 1;
          end else if (m_state == 1) begin
            if (sr_dir) begin
              if (m_alen == -1) m_alen = int'(sr_host_byte);
              else if (m_apos < 32) m_apos++;
              m_irq = 1;
            end else m_derr = 1;
          end else begin
            if (!sr_dir) begin
              if (m_rlen == -1) begin m_sr = 8'(m_size); m_rlen = m_size; end
              else if (m_rpos < m_size) begin
                m_sr = m_zero ? 8'h00 : 8'(m_mem[m_rpos]);
                m_rpos++;
              end
              m_irq = 1;
            end else m_derr = 1;
          end
          if (m_state == 1 && m_apos == m_alen) begin m_start = 1; m_state = 2; end
          if (m_state == 3 && m_rpos == m_rlen) m_state = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(port_q == m_port, "R4 port", port_q, m_port);
      chk(sr_irq == m_irq, "R8 sr_irq", sr_irq, m_irq);
      chk(sr_dev_byte == m_sr, "R9 sr_dev_byte", sr_dev_byte, m_sr);
      chk(busy == (m_state == 2), "R7 busy", busy, (m_state == 2));
      chk(disp_start == m_start, "R7 disp_start", disp_start, m_start);
      chk(hs_invalid == m_bad, "R3 hs_invalid", hs_invalid, m_bad);
      chk(dir_error == m_derr, "R8 dir_error", dir_error, m_derr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // Scenario state.
  logic [7:0] g_cmd;
  int g_nargs, g_rsize, g_byte_no, g_disp_at;
  logic g_known, g_poke;

  task automatic port_write(input logic [7:0] v);
    @(negedge clk);
    port_wr_en = 1'b1; port_wr_data = v;
    @(negedge clk);
    port_wr_en = 1'b0;
  endtask

  task automatic dispatch();
    chk(disp_start == 1'b1, "R7 start pulse", disp_start, 1);
    chk(disp_cmd == g_cmd, "R7 disp_cmd", disp_cmd, g_cmd);
    chk(int'(disp_arg_cnt) == g_nargs, "R7 disp_arg_cnt", disp_arg_cnt, g_nargs);
    for (int i = 0; i < g_nargs; i++) begin
      disp_arg_idx = 5'(i);
      #1;
      chk(disp_arg_byte == arg_of(g_cmd, i), "R6 arg readback", disp_arg_byte, arg_of(g_cmd, i));
    end
    if (g_poke) begin
      port_write(8'h18);
      chk(port_q == 8'h00, "R7 write ignored while busy", port_q, 8'h00);
    end
    @(negedge clk);
    for (int i = 0; i < g_rsize; i++) begin
      disp_rsp_we = 1'b1; disp_rsp_idx = 5'(i); disp_rsp_byte = rep_of(g_cmd, i);
      @(negedge clk);
    end
    disp_rsp_we = 1'b0;
    disp_done = 1'b1; disp_known = g_known; disp_rsp_size = 6'(g_rsize);
    @(negedge clk);
    disp_done = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b);
    sr_dir = 1'b1; sr_host_byte = b;
    port_write(port_q & 8'hEF);
    chk(port_q[3] == 1'b0, "R4 ack low after request", port_q, port_q & 8'hF7);
    if (busy) begin
      g_disp_at = g_byte_no;
      dispatch();
    end
    g_byte_no++;
    port_write(port_q | 8'h10);
  endtask

  task automatic host_recv(output logic [7:0] b);
    sr_dir = 1'b0;
    port_write(port_q & 8'hEF);
    b = sr_dev_byte;
    port_write(port_q | 8'h10);
  endtask

  task automatic exchange(input logic [7:0] cmd, input int nargs, input int rsize,
                          input logic known, input logic poke, input logic derr);
    int al, rl, n;
    logic [7:0] b;
    g_cmd = cmd; g_nargs = nargs; g_rsize = rsize; g_known = known; g_poke = poke;
    g_byte_no = 0; g_disp_at = -1;
    al = len_code(int'(cmd) % 8);
    rl = len_code((int'(cmd) / 8) % 8);
    host_send(cmd);
    if (derr) begin
      sr_dir = 1'b0;
      port_write(port_q & 8'hEF);
      chk(dir_error == 1'b1 && sr_irq == 1'b0, "R8 wrong direction", dir_error, 1);
      port_write(port_q | 8'h10);
    end
    if (al == -1) host_send(8'(nargs));
    for (int i = 0; i < nargs; i++) host_send(arg_of(cmd, i));
    chk(g_disp_at == ((al == -1) ? 1 : 0) + nargs, "R5 dispatch point",
        g_disp_at, ((al == -1) ? 1 : 0) + nargs);
    n = rl;
    if (rl == -1) begin
      host_recv(b);
      n = known ? rsize : 0;
      chk(int'(b) == n, "R9 in-band size", b, n);
    end
    for (int i = 0; i < n; i++) begin
      host_recv(b);
      if (known) chk(b == rep_of(cmd, i), "R11 reply byte", b, rep_of(cmd, i));
      else       chk(b == 8'h00, "R10 zero reply byte", b, 0);
    end
    chk(port_q == 8'h18 && !busy, "R9 back to idle", port_q, 8'h18);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    chk(port_q == 8'h18 && !busy && !sr_irq && !disp_start && !hs_invalid && !dir_error,
        "R1 reset state", port_q, 8'h18);

    port_write(8'h18);
    chk(port_q == 8'h18 && !sr_irq && !hs_invalid, "R2 same value", port_q, 8'h18);

    port_write(8'h98);
    chk(port_q == 8'h98 && !sr_irq, "R3 idle change stored", port_q, 8'h98);
    port_write(8'h18);
    port_write(8'h00);
    chk(hs_invalid == 1'b1 && !sr_irq, "R3 both low flagged", hs_invalid, 1);
    port_write(8'h18);
    chk(port_q == 8'h18, "R3 recover idle", port_q, 8'h18);

    sr_dir = 1'b0;
    port_write(8'h08);
    chk(dir_error == 1'b1 && !sr_irq && port_q == 8'h00, "R8 idle wrong direction", dir_error, 1);
    port_write(8'h10);
    chk(port_q == 8'h18, "R3 release restores ack", port_q, 8'h18);

    exchange(8'h09, 1, 1, 1'b1, 1'b0, 1'b0);
    exchange(8'h3F, 3, 5, 1'b1, 1'b0, 1'b0);
    exchange(8'h00, 0, 0, 1'b1, 1'b1, 1'b0);
    exchange(8'h52, 2, 2, 1'b1, 1'b0, 1'b1);
    exchange(8'h9A, 2, 3, 1'b0, 1'b0, 1'b0);
    exchange(8'hB8, 0, 4, 1'b0, 1'b0, 1'b0);
    exchange(8'h07, 32, 0, 1'b1, 1'b0, 1'b0);
    exchange(8'h3F, 0, 6, 1'b1, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule